// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a byte-addressed non-volatile memory that sits on a two-wire serial bus. It oversamples the clock and data lines with the system clock and detects start and stop conditions. It checks the device address byte against three strapped select inputs, takes a two-byte word address, and pulls the data line low for acknowledges and for the zero bits of read data.

Incoming data bytes go to a page buffer, one write strobe per byte. A commit strobe at the stop tells the buffer to start its internal programming cycle. Read bytes come from a synchronous memory array with one cycle of latency. A persistent address counter always holds the last address touched plus one. Reads step this counter across the whole array. Writes step it only within the current page.

The page buffer reports its programming cycle on a busy input. While that input is high, the controller does not acknowledge its device address, so a bus master can poll for completion.

Top module: `eeprom_slave`

## Requirements
- R1: A fall of SDA while SCL is high (start) aborts any byte in progress and restarts reception at the device address byte. A rise of SDA while SCL is high (stop) returns the controller to idle with SDA released, so a transaction begun after an aborted partial byte is served normally.
- R2: The device address byte is sent MSB first: bits 7..4 equal 1010, bits 3..1 equal the `dev_sel` inputs, and bit 0 is 1 for read and 0 for write. On a match, SDA is driven low through the ninth SCL pulse. On a mismatch there is no acknowledge, and no later byte is acknowledged until the next start.
- R3: While `wr_busy` is high, a matching device address byte is not acknowledged. Once `wr_busy` has fallen, the same byte is acknowledged again.
- R4: The first word-address byte supplies address bits ADDR_W-1..8 from its low bits, and its remaining high bits are ignored. The second byte supplies address bits 7..0. Both bytes are acknowledged.
- R5: Each data byte of a write is acknowledged and produces a one-cycle `pb_wr_valid` carrying the received byte and the current counter address.
- R6: After each written byte, only the low PAGE_W address bits advance, wrapping to the start of the same page. The higher bits are kept.
- R7: A stop that ends a transaction in which at least one data byte was written produces exactly one `pb_commit` pulse, in the cycle after the stop is detected. A transaction that only loads an address, or only polls, produces none.
- R8: A read with no word address returns the byte at the counter. The counter holds the last accessed address plus one across transactions.
- R9: A word-address load followed by a repeated start and a read device address returns the byte at the loaded address.
- R10: Each master acknowledge (SDA low in the ninth clock) during a read fetches and sends the next byte. The address wraps from the last array address to 0.
- R11: A master non-acknowledge ends the read. SDA stays released, no further byte is fetched, and the counter has advanced once per byte sent.
- R12: The controller changes its SDA drive only while SCL is low. It samples data on SCL rising edges and shifts read data out after SCL falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the wired bus |
| dev_sel | input | 3 | Strapped device select value |
| wr_busy | input | 1 | Internal programming cycle in progress |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| pb_wr_valid | output | 1 | One-cycle strobe for a received data byte |
| pb_wr_addr | output | ADDR_W | Array address for the received byte |
| pb_wr_data | output | 8 | Received data byte |
| pb_commit | output | 1 | Start-programming pulse after a write stop |
| mem_rd_en | output | 1 | Synchronous array read enable |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data, valid one cycle after the enable |

## Verification
A wrong address counter shows up at the ports within one transaction. The next current-address read or the next write strobe carries the wrong address, and a page-wrap or array-wrap error appears on the first byte past the boundary. A bad state or bit count shows within one byte time as a missing or misplaced acknowledge, as a read byte shifted by one bit, or as a commit pulse that is missing or extra at the next stop. A drive change during SCL high would corrupt the bus at once and appear as a false start or stop.

// File: rtl/eslv_pkg.sv
`timescale 1ns/1ps
package eslv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK_WAIT,
        S_ACK,
        S_TX,
        S_TX_WAIT,
        S_MACK
    } state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_e;

    typedef struct packed {
        state_e     st;
        phase_e     ph;
        logic [2:0] cnt;
        logic [6:0] sh;
        logic [6:0] tx;
        logic [7:0] rbuf;
        logic       rd_pend;
        logic       drive;
        logic       rw;
        logic       wrote;
        logic       commit;
    } ctl_s;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/eslv_sync.sv
`timescale 1ns/1ps
module eslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [1:0] raw;
    logic [1:0] now;
    logic [1:0] prev_q;

    assign raw = {scl_raw, sda_raw};

    // one synchronizer chain per bus line; index 1 is SCL, index 0 is SDA
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
        end
        assign now[g] = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= now;
    end

    assign sda_s     = now[0];
    assign scl_rise  = now[1] & ~prev_q[1];
    assign scl_fall  = ~now[1] & prev_q[1];
    assign start_evt = now[1] & prev_q[1] & prev_q[0] & ~now[0];
    assign stop_evt  = now[1] & prev_q[1] & ~prev_q[0] & now[0];

endmodule

// File: rtl/eslv_addr_ctr.sv
`timescale 1ns/1ps
module eslv_addr_ctr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc_full,
    input  logic              inc_page,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [PAGE_W-1:0] P_ONE = 1;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (ld_hi)    addr_d[ADDR_W-1:8] = byte_in[HI_W-1:0];
        if (ld_lo)    addr_d[7:0] = byte_in;
        if (inc_full) addr_d = addr_q + A_ONE;
        if (inc_page) addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + P_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/eeprom_slave.sv
`timescale 1ns/1ps
module eeprom_slave #(
    parameter int ADDR_W      = 15,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        dev_sel,
    input  logic              wr_busy,
    output logic              sda_drive_low,
    output logic              pb_wr_valid,
    output logic [ADDR_W-1:0] pb_wr_addr,
    output logic [7:0]        pb_wr_data,
    output logic              pb_commit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    import eslv_pkg::*;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic ld_hi, ld_lo, inc_full, inc_page, rd_en, wr_v;
    logic [ADDR_W-1:0] ctr_addr;
    logic [7:0] byte_in;
    ctl_s q, n;

    eslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    eslv_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .inc_full(inc_full), .inc_page(inc_page), .byte_in(byte_in),
        .addr(ctr_addr)
    );

    assign byte_in = {q.sh, sda_s};

    always_comb begin
        n        = q;
        n.commit = 1'b0;
        n.rd_pend = 1'b0;
        ld_hi    = 1'b0;
        ld_lo    = 1'b0;
        inc_full = 1'b0;
        inc_page = 1'b0;
        rd_en    = 1'b0;
        wr_v     = 1'b0;
        if (q.rd_pend) n.rbuf = mem_rd_data;

        if (stop_evt) begin
            n.st     = S_IDLE;
            n.drive  = 1'b0;
            n.commit = q.wrote;
            n.wrote  = 1'b0;
        end else if (start_evt) begin
            n.st    = S_RX;
            n.ph    = PH_DEV;
            n.cnt   = '0;
            n.drive = 1'b0;
        end else begin
            case (q.st)
                S_RX: if (scl_rise) begin
                    n.sh  = byte_in[6:0];
                    n.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        n.st = S_ACK_WAIT;
                        case (q.ph)
                            PH_DEV: begin
                                if (byte_in[7:4] == DEV_PREFIX && byte_in[3:1] == dev_sel && !wr_busy) begin
                                    n.rw = byte_in[0];
                                    if (byte_in[0]) begin
                                        rd_en     = 1'b1;
                                        inc_full  = 1'b1;
                                        n.rd_pend = 1'b1;
                                    end
                                end else begin
                                    n.st = S_IDLE;
                                end
                            end
                            PH_AHI: ld_hi = 1'b1;
                            PH_ALO: ld_lo = 1'b1;
                            default: begin
                                wr_v     = 1'b1;
                                inc_page = 1'b1;
                                n.wrote  = 1'b1;
                            end
                        endcase
                    end
                end
                S_ACK_WAIT: if (scl_fall) begin
                    n.drive = 1'b1;
                    n.st    = S_ACK;
                end
                S_ACK: if (scl_fall) begin
                    n.drive = 1'b0;
                    n.cnt   = '0;
                    if (q.ph == PH_DEV && q.rw) begin
                        n.tx    = q.rbuf[6:0];
                        n.drive = ~q.rbuf[7];
                        n.st    = S_TX;
                    end else begin
                        n.st = S_RX;
                        case (q.ph)
                            PH_DEV:  n.ph = PH_AHI;
                            PH_AHI:  n.ph = PH_ALO;
                            default: n.ph = PH_DATA;
                        endcase
                    end
                end
                S_TX: if (scl_fall) begin
                    if (q.cnt == 3'd7) begin
                        n.drive = 1'b0;
                        n.cnt   = '0;
                        n.st    = S_MACK;
                    end else begin
                        n.drive = ~q.tx[6];
                        n.tx    = {q.tx[5:0], 1'b0};
                        n.cnt   = q.cnt + 3'd1;
                    end
                end
                S_MACK: if (scl_rise) begin
                    if (!sda_s) begin
                        rd_en     = 1'b1;
                        inc_full  = 1'b1;
                        n.rd_pend = 1'b1;
                        n.st      = S_TX_WAIT;
                    end else begin
                        n.st = S_IDLE;
                    end
                end
                S_TX_WAIT: if (scl_fall) begin
                    n.tx    = q.rbuf[6:0];
                    n.drive = ~q.rbuf[7];
                    n.cnt   = '0;
                    n.st    = S_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_drive_low = q.drive;
    assign pb_commit     = q.commit;
    assign pb_wr_valid   = wr_v;
    assign pb_wr_addr    = ctr_addr;
    assign pb_wr_data    = byte_in;
    assign mem_rd_en     = rd_en;
    assign mem_rd_addr   = ctr_addr;

endmodule

// File: rtl/eslv_checker.sv
`timescale 1ns/1ps
module eslv_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_drive_low,
    input logic wr_busy,
    input logic pb_wr_valid,
    input logic pb_commit,
    input logic mem_rd_en,
    input logic stop_evt
);
    // R12: drive edges only while the clock line is low
    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) || $fell(sda_drive_low)) |-> !scl_in);

    // R1: a stop leaves the data line released
    p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_drive_low);

    // R3: no byte reaches the page buffer during programming
    p_no_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr_valid |-> !wr_busy);

    // R7: commit follows a detected stop
    p_commit_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pb_commit |-> $past(stop_evt));

    // R7: commit is a single-cycle pulse
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pb_commit |=> !pb_commit);

    // R5: write strobe and array read never coincide
    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_wr_valid && mem_rd_en));

endmodule

bind eeprom_slave eslv_checker u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .scl_in(scl_in),
    .sda_drive_low(sda_drive_low),
    .wr_busy(wr_busy),
    .pb_wr_valid(pb_wr_valid),
    .pb_commit(pb_commit),
    .mem_rd_en(mem_rd_en),
    .stop_evt(stop_evt)
);

// File: tb/eeprom_slave_bench.sv
`timescale 1ns/1ps
module eeprom_slave_bench;
    localparam int AW   = 10;
    localparam int Q    = 6;
    localparam int BUSY = 400;
    localparam int NV   = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};
    // each entry: {address, data} written then read back at random
    localparam logic [17:0] VEC [NV] = '{
        {10'h005, 8'hA5}, {10'h13F, 8'h3C}, {10'h200, 8'h77}, {10'h3FF, 8'hC1},
        {10'h3FE, 8'h9D}, {10'h001, 8'h4B}, {10'h002, 8'hE7}, {10'h040, 8'h00},
        {10'h2AC, 8'h5E}, {10'h2AB, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_busy;
    logic sda_drive_low, pb_wr_valid, pb_commit, mem_rd_en;
    logic [AW-1:0] pb_wr_addr, mem_rd_addr;
    logic [7:0] pb_wr_data;
    logic [7:0] mem_rd_data;
    wire sda_bus = sda_m & ~sda_drive_low;

    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];
    int busy_cnt = 0;
    int n_commit = 0;
    int n_viol = 0;
    logic [AW-1:0] last_wa;
    logic [7:0] last_wd;
    logic drv_prev = 1'b0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eeprom_slave #(.ADDR_W(AW), .PAGE_W(6), .SYNC_STAGES(2)) u_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .dev_sel(SEL), .wr_busy(wr_busy), .sda_drive_low(sda_drive_low),
        .pb_wr_valid(pb_wr_valid), .pb_wr_addr(pb_wr_addr), .pb_wr_data(pb_wr_data),
        .pb_commit(pb_commit), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    assign wr_busy = (busy_cnt != 0);

    // page buffer and array model
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (pb_wr_valid) begin
            mem[pb_wr_addr] <= pb_wr_data;
            last_wa <= pb_wr_addr;
            last_wd <= pb_wr_data;
        end
        if (pb_commit) begin
            n_commit <= n_commit + 1;
            busy_cnt <= BUSY;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
        drv_prev <= sda_drive_low;
        if (rst_n && drv_prev !== sda_drive_low && scl_m) n_viol <= n_viol + 1;
    end

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic m_start;
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(~mack);
    endtask

    task automatic wait_ready;
        tick(4);
        while (wr_busy) tick(1);
        tick(4);
    endtask

    // random read of one byte; returns AND of all acknowledges
    task automatic rd_rand(input logic [7:0] hi, input logic [7:0] lo,
                           output logic [7:0] d, output logic ok);
        logic a0, a1, a2, a3;
        m_start;
        m_wbyte(DEV_W, a0);
        m_wbyte(hi, a1);
        m_wbyte(lo, a2);
        m_start;
        m_wbyte(DEV_R, a3);
        m_rbyte(1'b0, d);
        m_stop;
        ok = a0 & a1 & a2 & a3;
    endtask

    task automatic rd_cur(output logic [7:0] d, output logic ok);
        m_start;
        m_wbyte(DEV_R, ok);
        m_rbyte(1'b0, d);
        m_stop;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 180000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack, ok, a1, a2, a3, a4;
        logic [7:0] d;
        int c0;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // reset state
        chk("R1 reset drive", sda_drive_low, 0);
        chk("R7 reset commit", pb_commit, 0);
        chk("R5 reset strobe", pb_wr_valid, 0);

        // table: byte write then random read of each address
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            logic [7:0] dv;
            a  = VEC[v][17:8];
            dv = VEC[v][7:0];
            c0 = n_commit;
            m_start;
            m_wbyte(DEV_W, a1);
            m_wbyte({6'b0, a[9:8]}, a2);
            m_wbyte(a[7:0], a3);
            m_wbyte(dv, a4);
            m_stop;
            tick(2);
            exp_mem[a] = dv;
            chk("R5 write acks", {a1, a2, a3, a4}, 4'hF);
            chk("R5 strobe addr", last_wa, a);
            chk("R5 strobe data", last_wd, dv);
            chk("R7 one commit", n_commit - c0, 1);
            wait_ready;
            c0 = n_commit;
            rd_rand({6'b0, a[9:8]}, a[7:0], d, ok);
            chk("R9 random read acks", ok, 1);
            chk("R9 random read data", d, dv);
            chk("R7 no commit on address load", n_commit - c0, 0);
        end

        // current-address read after last table read of 0x2AB
        rd_cur(d, ok);
        chk("R8 current read ack", ok, 1);
        chk("R8 current read data", d, exp_mem[10'h2AC]);

        // ignored high bits of the first word-address byte
        rd_rand(8'hFE, 8'h00, d, ok);
        chk("R4 high bits ignored ack", ok, 1);
        chk("R4 high bits ignored data", d, exp_mem[10'h200]);

        // device address mismatch: wrong select, then wrong prefix
        m_start;
        m_wbyte({4'b1010, 3'b011, 1'b0}, ack);
        chk("R2 select mismatch nack", ack, 0);
        m_wbyte(8'h00, ack);
        chk("R2 silent until start", ack, 0);
        m_stop;
        m_start;
        m_wbyte({4'b1011, SEL, 1'b1}, ack);
        chk("R2 prefix mismatch nack", ack, 0);
        m_stop;

        // page write wrapping inside page 0, then busy polling
        m_start;
        m_wbyte(DEV_W, a1);
        m_wbyte(8'h00, a2);
        m_wbyte(8'h3E, a3);
        m_wbyte(8'h11, a4);
        m_wbyte(8'h22, ack);
        m_wbyte(8'h33, ok);
        m_stop;
        exp_mem[10'h03E] = 8'h11;
        exp_mem[10'h03F] = 8'h22;
        exp_mem[10'h000] = 8'h33;
        chk("R6 page write acks", {a1, a2, a3, a4, ack, ok}, 6'h3F);
        chk("R6 wrapped strobe addr", last_wa, 10'h000);
        c0 = n_commit;
        m_start;
        m_wbyte(DEV_W, ack);
        m_stop;
        chk("R3 busy nack", ack, 0);
        wait_ready;
        m_start;
        m_wbyte(DEV_W, ack);
        m_stop;
        chk("R3 ack after busy", ack, 1);
        chk("R7 poll no commit", n_commit - c0, 0);
        rd_rand(8'h00, 8'h00, d, ok);
        chk("R6 wrap landed at page start", d, 8'h33);
        rd_rand(8'h00, 8'h40, d, ok);
        chk("R6 next page untouched", d, exp_mem[10'h040]);

        // sequential read across the array end
        c0 = n_commit;
        m_start;
        m_wbyte(DEV_W, a1);
        m_wbyte(8'h03, a2);
        m_wbyte(8'hFE, a3);
        m_start;
        m_wbyte(DEV_R, a4);
        chk("R10 seq acks", {a1, a2, a3, a4}, 4'hF);
        m_rbyte(1'b1, d);
        chk("R10 seq byte 0", d, exp_mem[10'h3FE]);
        m_rbyte(1'b1, d);
        chk("R10 seq byte 1", d, exp_mem[10'h3FF]);
        m_rbyte(1'b0, d);
        chk("R10 seq wrap to 0", d, exp_mem[10'h000]);
        tick(Q);
        chk("R11 released after nack", sda_drive_low, 0);
        m_stop;
        chk("R11 no commit after read", n_commit - c0, 0);
        rd_cur(d, ok);
        chk("R11 counter advanced per byte", d, exp_mem[10'h001]);

        // start in mid byte aborts, then a read is served
        m_start;
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b0);
        m_start;
        m_wbyte(DEV_R, ack);
        chk("R1 ack after abort", ack, 1);
        m_rbyte(1'b0, d);
        m_stop;
        chk("R1 data after abort", d, exp_mem[10'h002]);
        chk("R1 released in idle", sda_drive_low, 0);

        chk("R12 drive changed only with scl low", n_viol, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule